// File: doc/BRIEF.md
# Composite Good/Faulty Logic Evaluator

This unit evaluates single gate operations over the composite signal algebra used when tests are generated for stuck-at faults. Each signal carries two three-valued components: the value it takes in the fault-free circuit and the value it takes in the faulty circuit. Two components give the familiar D (good 1, faulty 0) and D-bar (good 0, faulty 1). The unit computes NAND, AND, OR, NOT or cube intersection on two operand codes. It returns the composite result and a flag that marks an intersection of two incompatible specified values.

A search engine calls the unit once per implication or intersection step. Gates are computed separately on the good and faulty components with three-valued logic and the halves are then repacked. This makes D and D-bar pass through gates correctly. One parameter selects the full nine-valued set, where one component can be unknown while the other is known. The other choice is the reduced five-valued set, where any half-known value collapses to fully unknown. A second parameter selects a registered or a purely combinational output.

Top module: `dcalc_unit`

## Requirements
- R1: An operand or result code is 4 bits, with the good component in bits [3:2] and the faulty component in bits [1:0]. Each component uses 00 = 0, 01 = 1, 10 = X. An input component of 11 is treated as X, and no result component is ever 11.
- R2: Opcode 000 is NAND, computed per component. A 0/0 operand forces 1/1 whatever the other operand holds. 1 NAND D = D-bar (0001), 1 NAND D-bar = D (0100), D NAND D-bar = 1/1, and D NAND D = D-bar.
- R3: Opcode 001 is AND and opcode 010 is OR, both computed per component. Opcode 011 is NOT of the left operand, and the right operand has no effect on it.
- R4: Opcode 100 is intersection, computed per component. X meeting v gives v, and two equal values give that value.
- R5: The conflict flag rises only for intersection, and only when some component meets 0 with 1. Every other opcode leaves it low. The result is don't-care while the flag is high.
- R6: Opcodes 101, 110 and 111 are reserved. They give X/X (1010) with the conflict flag low.
- R7: With NINE_VALUED = 0, any operand or result with exactly one X component becomes X/X, so only 0, 1, X, D and D-bar appear.
- R8: With NINE_VALUED = 1, half-known results are kept. For example, X/X NAND D gives X/1 (1001).
- R9: With OUT_REG = 1, the outputs show the result of the inputs present at the previous rising clock edge, and an active-low reset sets them to X/X with the flag low. With OUT_REG = 0, the outputs follow the inputs with no clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 3 | Operation select |
| lhs_i | input | 4 | Left operand code |
| rhs_i | input | 4 | Right operand code |
| res_o | output | 4 | Result code |
| clash_o | output | 1 | Intersection conflict flag |

## Verification
The bench builds two copies side by side. One uses the defaults: nine-valued, registered. The other is five-valued and combinational. Both receive every opcode, including the reserved ones, crossed with all sixteen codes on each operand, illegal component encodings among them. This covers every gate entry, the one-cycle latency and the reset value of the registered copy, and the folding of half-known codes in the reduced copy. Expected values come from an interval model in which 0, 1 and X are the ranges [0,0], [1,1] and [0,1].

// File: rtl/dcalc_pkg.sv
package dcalc_pkg;
    localparam int HALF_W = 2;
    localparam int CODE_W = 2 * HALF_W;
    localparam int OP_W   = 3;

    localparam logic [HALF_W-1:0] TV_ZERO = 2'b00;
    localparam logic [HALF_W-1:0] TV_ONE  = 2'b01;
    localparam logic [HALF_W-1:0] TV_UNK  = 2'b10;

    localparam logic [CODE_W-1:0] CODE_X = {TV_UNK, TV_UNK};

    typedef enum logic [OP_W-1:0] {
        OP_NAND  = 3'd0,
        OP_AND   = 3'd1,
        OP_OR    = 3'd2,
        OP_NOT   = 3'd3,
        OP_ISECT = 3'd4
    } dop_e;

    // Illegal 11 component is read as unknown.
    function automatic logic [HALF_W-1:0] tv_norm(input logic [HALF_W-1:0] v);
        return (v == 2'b11) ? TV_UNK : v;
    endfunction

    function automatic logic [HALF_W-1:0] tv_not(input logic [HALF_W-1:0] v);
        case (v)
            TV_ZERO: return TV_ONE;
            TV_ONE:  return TV_ZERO;
            default: return TV_UNK;
        endcase
    endfunction

    function automatic logic [HALF_W-1:0] tv_and(input logic [HALF_W-1:0] x,
                                                 input logic [HALF_W-1:0] y);
        if (x == TV_ZERO || y == TV_ZERO) return TV_ZERO;
        if (x == TV_ONE && y == TV_ONE)   return TV_ONE;
        return TV_UNK;
    endfunction
endpackage

// File: rtl/dcalc_fold.sv
module dcalc_fold
    import dcalc_pkg::*;
#(
    parameter bit NINE_VALUED = 1'b1
) (
    input  logic [CODE_W-1:0] code_i,
    output logic [CODE_W-1:0] code_o
);
    logic [HALF_W-1:0] good_n;
    logic [HALF_W-1:0] bad_n;

    assign good_n = tv_norm(code_i[CODE_W-1:HALF_W]);
    assign bad_n  = tv_norm(code_i[HALF_W-1:0]);

    generate
        if (NINE_VALUED) begin : g_keep
            assign code_o = {good_n, bad_n};
        end else begin : g_collapse
            always_comb begin
                if ((good_n == TV_UNK) != (bad_n == TV_UNK)) code_o = CODE_X;
                else                                         code_o = {good_n, bad_n};
            end
        end
    endgenerate
endmodule

// File: rtl/dcalc_half.sv
module dcalc_half
    import dcalc_pkg::*;
(
    input  logic [OP_W-1:0]   op_i,
    input  logic [HALF_W-1:0] x_i,
    input  logic [HALF_W-1:0] y_i,
    output logic [HALF_W-1:0] z_o,
    output logic              clash_o
);
    always_comb begin
        z_o     = TV_UNK;
        clash_o = 1'b0;
        case (op_i)
            OP_NAND: z_o = tv_not(tv_and(x_i, y_i));
            OP_AND:  z_o = tv_and(x_i, y_i);
            OP_OR:   z_o = tv_not(tv_and(tv_not(x_i), tv_not(y_i)));
            OP_NOT:  z_o = tv_not(x_i);
            OP_ISECT: begin
                if (x_i == TV_UNK)    z_o = y_i;
                else if (y_i == TV_UNK || x_i == y_i) z_o = x_i;
                else                  clash_o = 1'b1;
            end
            default: z_o = TV_UNK;
        endcase
    end
endmodule

// File: rtl/dcalc_unit.sv
module dcalc_unit
    import dcalc_pkg::*;
#(
    parameter bit NINE_VALUED = 1'b1,
    parameter bit OUT_REG     = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OP_W-1:0]   op_i,
    input  logic [CODE_W-1:0] lhs_i,
    input  logic [CODE_W-1:0] rhs_i,
    output logic [CODE_W-1:0] res_o,
    output logic              clash_o
);
    localparam int NUM_HALF = CODE_W / HALF_W;

    logic [CODE_W-1:0]   lhs_f;
    logic [CODE_W-1:0]   rhs_f;
    logic [CODE_W-1:0]   raw_w;
    logic [CODE_W-1:0]   res_w;
    logic [NUM_HALF-1:0] half_clash;
    logic                clash_w;

    dcalc_fold #(.NINE_VALUED(NINE_VALUED)) u_fold_lhs (.code_i(lhs_i), .code_o(lhs_f));
    dcalc_fold #(.NINE_VALUED(NINE_VALUED)) u_fold_rhs (.code_i(rhs_i), .code_o(rhs_f));

    generate
        for (genvar h = 0; h < NUM_HALF; h++) begin : g_half
            dcalc_half u_half (
                .op_i   (op_i),
                .x_i    (lhs_f[h*HALF_W +: HALF_W]),
                .y_i    (rhs_f[h*HALF_W +: HALF_W]),
                .z_o    (raw_w[h*HALF_W +: HALF_W]),
                .clash_o(half_clash[h])
            );
        end
    endgenerate

    assign clash_w = |half_clash;

    dcalc_fold #(.NINE_VALUED(NINE_VALUED)) u_fold_res (.code_i(raw_w), .code_o(res_w));

    generate
        if (OUT_REG) begin : g_reg
            logic [CODE_W-1:0] res_q;
            logic              clash_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    res_q   <= CODE_X;
                    clash_q <= 1'b0;
                end else begin
                    res_q   <= res_w;
                    clash_q <= clash_w;
                end
            end
            assign res_o   = res_q;
            assign clash_o = clash_q;
        end else begin : g_comb
            assign res_o   = res_w;
            assign clash_o = clash_w;
        end
    endgenerate
endmodule

// File: rtl/dcalc_unit_chk.sv
module dcalc_unit_chk
    import dcalc_pkg::*;
#(
    parameter bit NINE_VALUED = 1'b1,
    parameter bit OUT_REG     = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [OP_W-1:0]   op_i,
    input logic [CODE_W-1:0] lhs_i,
    input logic [CODE_W-1:0] rhs_i,
    input logic [CODE_W-1:0] res_o,
    input logic              clash_o
);
    logic [OP_W-1:0]   op_q;
    logic [CODE_W-1:0] lhs_q;
    logic [CODE_W-1:0] rhs_q;
    logic              seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q   <= '0;
            lhs_q  <= '0;
            rhs_q  <= '0;
            seen_q <= 1'b0;
        end else begin
            op_q   <= op_i;
            lhs_q  <= lhs_i;
            rhs_q  <= rhs_i;
            seen_q <= 1'b1;
        end
    end

    logic [OP_W-1:0]   op_v;
    logic [CODE_W-1:0] lhs_v;
    logic [CODE_W-1:0] rhs_v;
    logic              ready;
    logic              rhs_five;

    assign op_v  = OUT_REG ? op_q  : op_i;
    assign lhs_v = OUT_REG ? lhs_q : lhs_i;
    assign rhs_v = OUT_REG ? rhs_q : rhs_i;
    assign ready = OUT_REG ? seen_q : 1'b1;
    assign rhs_five = (rhs_v == 4'b0000) || (rhs_v == 4'b0101) || (rhs_v == 4'b1010) ||
                      (rhs_v == 4'b0100) || (rhs_v == 4'b0001);

    // R5
    clash_only_isect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && clash_o) |-> (op_v == OP_ISECT));

    // R2
    nand_zero_forces_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && op_v == OP_NAND && lhs_v == 4'b0000) |-> (res_o == 4'b0101));

    // R4
    isect_unknown_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && op_v == OP_ISECT && lhs_v == 4'b1010 && rhs_five)
        |-> (res_o == rhs_v && !clash_o));

    // R6
    reserved_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && op_v > OP_ISECT) |-> (res_o == 4'b1010 && !clash_o));

    // R1
    no_illegal_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_o[3:2] != 2'b11) && (res_o[1:0] != 2'b11));

    generate
        if (!NINE_VALUED) begin : g_five
            // R7
            five_value_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (res_o[3:2] == 2'b10) == (res_o[1:0] == 2'b10));
        end
        if (OUT_REG) begin : g_regd
            // R9
            reset_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !seen_q |-> (res_o == 4'b1010 && !clash_o));
        end
    endgenerate
endmodule

bind dcalc_unit dcalc_unit_chk #(.NINE_VALUED(NINE_VALUED), .OUT_REG(OUT_REG)) u_chk (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .lhs_i(lhs_i), .rhs_i(rhs_i),
    .res_o(res_o), .clash_o(clash_o)
);

// File: tb/test_dcalc_unit.sv
`timescale 1ns/1ps
module test_dcalc_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] op = 3'd0;
    logic [3:0] lhs = 4'd0;
    logic [3:0] rhs = 4'd0;
    logic [3:0] res9, res5;
    logic       cl9, cl5;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    dcalc_unit i_dcalc_unit (
        .clk(clk), .rst_n(rst_n), .op_i(op), .lhs_i(lhs), .rhs_i(rhs),
        .res_o(res9), .clash_o(cl9)
    );

    dcalc_unit #(.NINE_VALUED(1'b0), .OUT_REG(1'b0)) i_dcalc_unit_five (
        .clk(clk), .rst_n(rst_n), .op_i(op), .lhs_i(lhs), .rhs_i(rhs),
        .res_o(res5), .clash_o(cl5)
    );

    // interval model: lo/hi bounds of a component
    function automatic logic [1:0] bnd(input logic [1:0] c);
        if (c == 2'b00) return 2'b00;
        if (c == 2'b01) return 2'b11;
        return 2'b10;
    endfunction

    function automatic logic [2:0] ref_half(input logic [2:0] o, input logic [1:0] x, input logic [1:0] y);
        logic [1:0] bx, by;
        logic lo, hi;
        bx = bnd(x); by = bnd(y);
        case (o)
            3'd0: begin lo = ~(bx[1] & by[1]); hi = ~(bx[0] & by[0]); end
            3'd1: begin lo = bx[0] & by[0];    hi = bx[1] & by[1];    end
            3'd2: begin lo = bx[0] | by[0];    hi = bx[1] | by[1];    end
            3'd3: begin lo = ~bx[1];           hi = ~bx[0];           end
            3'd4: begin lo = bx[0] | by[0];    hi = bx[1] & by[1];    end
            default: begin lo = 1'b0; hi = 1'b1; end
        endcase
        if (lo & ~hi) return 3'b110;
        if (lo == hi) return {1'b0, 1'b0, lo};
        return 3'b010;
    endfunction

    function automatic logic [3:0] b_fold(input logic [3:0] c, input bit nine);
        logic [1:0] g, f;
        g = (c[3:2] == 2'b11) ? 2'b10 : c[3:2];
        f = (c[1:0] == 2'b11) ? 2'b10 : c[1:0];
        if (!nine && ((g == 2'b10) != (f == 2'b10))) return 4'b1010;
        return {g, f};
    endfunction

    function automatic logic [4:0] ref_eval(input logic [2:0] o, input logic [3:0] a,
                                            input logic [3:0] b, input bit nine);
        logic [3:0] fa, fb;
        logic [2:0] hg, hf;
        fa = b_fold(a, nine); fb = b_fold(b, nine);
        hg = ref_half(o, fa[3:2], fb[3:2]);
        hf = ref_half(o, fa[1:0], fb[1:0]);
        return {hg[2] | hf[2], b_fold({hg[1:0], hf[1:0]}, nine)};
    endfunction

    task automatic cmp(input string tag, input string what, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s op=%0d lhs=%b rhs=%b actual=%b expected=%b", tag, what, op, lhs, rhs, act, exp);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic run(input logic [2:0] o, input logic [3:0] a, input logic [3:0] b, input string tag);
        logic [4:0] e9, e5;
        op = o; lhs = a; rhs = b;
        e9 = ref_eval(o, a, b, 1'b1);
        e5 = ref_eval(o, a, b, 1'b0);
        #2;
        cmp({tag, "/R7"}, "five clash", {3'b0, cl5}, {3'b0, e5[4]});
        if (!e5[4]) cmp({tag, "/R7"}, "five result", res5, e5[3:0]);
        @(negedge clk);
        cmp({tag, "/R9"}, "nine clash", {3'b0, cl9}, {3'b0, e9[4]});
        if (!e9[4]) cmp({tag, "/R9"}, "nine result", res9, e9[3:0]);
    endtask

    initial begin
        #1600000;
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state of the registered copy
        cmp("R9", "reset result", res9, 4'b1010);
        cmp("R9", "reset clash", {3'b0, cl9}, 4'b0000);
        rst_n = 1'b1;
        @(negedge clk);

        for (int o = 0; o < 8; o++) begin
            for (int a = 0; a < 16; a++) begin
                for (int b = 0; b < 16; b++) begin
                    string t;
                    case (o)
                        0: t = "R2";
                        1, 2, 3: t = "R3";
                        4: t = "R4/R5";
                        default: t = "R6";
                    endcase
                    run(o[2:0], a[3:0], b[3:0], t);
                end
            end
        end

        // directed cases
        run(3'd0, 4'b1010, 4'b0100, "R8");
        cmp("R8", "X nand D nine", res9, 4'b1001);
        cmp("R7", "X nand D five", res5, 4'b1010);
        run(3'd4, 4'b1111, 4'b0001, "R1");
        cmp("R1", "illegal as X", res9, 4'b0001);
        run(3'd0, 4'b0101, 4'b0100, "R2");
        cmp("R2", "1 nand D", res9, 4'b0001);
        run(3'd0, 4'b0100, 4'b0001, "R2");
        cmp("R2", "D nand Dbar", res9, 4'b0101);
        run(3'd4, 4'b0100, 4'b0000, "R5");
        cmp("R5", "D isect 0 clash", {3'b0, cl9}, 4'b0001);
        run(3'd3, 4'b0100, 4'b0000, "R3");
        cmp("R3", "not D rhs0", res9, 4'b0001);
        run(3'd3, 4'b0100, 4'b0101, "R3");
        cmp("R3", "not D rhs1", res9, 4'b0001);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule